// File: doc/BRIEF.md
# Page Write Collector with Upper-Quarter Lock

This block sits between a serial-bus slave front end and a byte-wide nonvolatile array. The front end tells it when a write transaction opens, giving the target address. It then hands over each data byte as that byte completes, and it signals the end of the transaction. The block holds the bytes in a one-page staging store. Each byte goes to a slot chosen by the low address bits, and the slot index wraps inside the page, so a long burst keeps only its most recent page of bytes.

When the transaction ends, the block copies every staged slot into the array, one write per clock. It also raises a busy flag for a programmable programming time. The front end uses that flag to stop acknowledging. A lock input guards the top quarter of the address space. When the lock is set and the page lies in that quarter, the bytes are still collected, but they are dropped at copy time and a sticky status bit records the drop.

Top module: `wrpage_collect`

## Requirements
- R1: After reset, `busy_o`, `arr_we_o` and `prot_drop_o` are all 0.
- R2: A byte lands in the slot given by the low log2(PAGE) bits of the open address. The slot index steps up by one per byte and wraps from PAGE-1 to 0. Each array write carries the transaction's upper address bits unchanged, with the slot index as its low bits.
- R3: If more than PAGE bytes arrive in one transaction, the later bytes overwrite the earliest ones in arrival order, so only the last PAGE bytes reach the array.
- R4: At the end of a transaction, each slot written in that transaction produces exactly one array write. The writes come in ascending slot order, at most one per clock, and all occur while `busy_o` is 1. Unwritten slots produce no write.
- R5: An end of transaction with no complete data byte produces no array write and leaves `busy_o` at 0.
- R6: An end of transaction that carries data raises `busy_o` on the next clock. `busy_o` then stays high for exactly PROG_CYC clocks.
- R7: While `busy_o` is 1, the open, byte and end inputs have no effect. A transaction opened during busy therefore does not exist afterwards, and a later byte and end without a new open produce nothing.
- R8: If `wp_i` is 1 at the end of a transaction whose address has its two top bits equal to 11 (C00h–FFFh), no array write occurs and `prot_drop_o` becomes 1.
- R9: With `wp_i` at 0, pages in the top quarter are written normally. With `wp_i` at 1, pages below C00h are written normally.
- R10: Once set, `prot_drop_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a write transaction (one-cycle pulse) |
| start_addr_i | input | ADDR_W | Target address of the transaction |
| byte_i | input | 1 | A data byte has completed (one-cycle pulse) |
| byte_data_i | input | DATA_W | The completed byte |
| stop_i | input | 1 | Ends the transaction (one-cycle pulse) |
| wp_i | input | 1 | Upper-quarter write lock |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Programming cycle in progress |
| prot_drop_o | output | 1 | Sticky: locked bytes were discarded |

## Verification
The bench keeps the default 12-bit address, 8-bit data and 32-byte page. It lowers PROG_CYC to 48, which is just above the 34-clock copy latency. With that value, many complete transactions fit in a short run, and the exact busy length can be counted clock by clock. The short cycle also lets the bench place open, byte and end pulses in the middle of a busy window, test slot wrap at the page end and overwrite past 32 bytes, and exercise the lock on both sides of the C00h boundary.

// File: rtl/wrpage_pkg.sv
package wrpage_pkg;

  // Lock applies only when the pin is set and the page sits in the top quarter.
  function automatic logic in_locked_quarter(input logic wp, input logic [1:0] msb);
    return wp && (msb == 2'b11);
  endfunction

endpackage

// File: rtl/wrpage_slots.sv
module wrpage_slots #(
  parameter int PAGE   = 32,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(PAGE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);

  logic [DATA_W-1:0] mem_q [PAGE];
  logic [PAGE-1:0]   vld_q;

  // Data store: no reset so it can map onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
    rd_data_o <= mem_q[rd_idx_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      if (clr_i)        vld_q           <= '0;
      else if (wr_en_i) vld_q[wr_idx_i] <= 1'b1;
      rd_vld_o <= vld_q[rd_idx_i];
    end
  end

  assign any_vld_o = |vld_q;

endmodule

// File: rtl/wrpage_timer.sv
module wrpage_timer #(
  parameter int PROG_CYC = 1250000,
  localparam int CW = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic busy_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (go_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(PROG_CYC - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cnt_q != '0) |=> busy_o);
  a_r6_busy_ends: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cnt_q == '0 && !go_i) |=> !busy_o);

endmodule

// File: rtl/wrpage_collect.sv
module wrpage_collect #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int PAGE     = 32,
  parameter int PROG_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o,
  output logic              prot_drop_o
);
  import wrpage_pkg::*;

  localparam int PTR_W = $clog2(PAGE);
  localparam int HI_W  = ADDR_W - PTR_W;

  if (PROG_CYC < PAGE + 2) begin : g_prog_too_short
    $error("PROG_CYC must cover the copy scan");
  end

  logic              open_q, scan_q, act_d, prot_q;
  logic [PTR_W-1:0]  ptr_q, si_q, si_d;
  logic [HI_W-1:0]   base_q;
  logic [DATA_W-1:0] rd_data;
  logic              rd_vld, any_vld;
  logic              take_start, take_byte, commit_go;

  assign take_start = start_i && !busy_o;
  assign take_byte  = byte_i && open_q && !busy_o && !take_start;
  assign commit_go  = stop_i && open_q && any_vld && !busy_o && !take_start;

  wrpage_slots #(.PAGE(PAGE), .DATA_W(DATA_W)) i_slots (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (take_start),
    .wr_en_i   (take_byte),
    .wr_idx_i  (ptr_q),
    .wr_data_i (byte_data_i),
    .rd_idx_i  (si_q),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .any_vld_o (any_vld)
  );

  wrpage_timer #(.PROG_CYC(PROG_CYC)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .go_i   (commit_go),
    .busy_o (busy_o)
  );

  // Transaction capture
  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      ptr_q  <= '0;
      base_q <= '0;
    end else if (take_start) begin
      open_q <= 1'b1;
      ptr_q  <= start_addr_i[PTR_W-1:0];
      base_q <= start_addr_i[ADDR_W-1:PTR_W];
    end else if (take_byte) begin
      ptr_q  <= ptr_q + 1'b1;
    end else if (stop_i && !busy_o) begin
      open_q <= 1'b0;
    end
  end

  // Copy scan: one slot per clock, lock decided when the copy starts
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q <= 1'b0;
      si_q   <= '0;
      si_d   <= '0;
      act_d  <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      act_d <= scan_q;
      si_d  <= si_q;
      if (commit_go) begin
        scan_q <= 1'b1;
        si_q   <= '0;
        prot_q <= in_locked_quarter(wp_i, base_q[HI_W-1 -: 2]);
      end else if (scan_q) begin
        si_q <= si_q + 1'b1;
        if (si_q == PTR_W'(PAGE - 1)) scan_q <= 1'b0;
      end
    end
  end

  // Registered array port and sticky status
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we_o    <= 1'b0;
      arr_addr_o  <= '0;
      arr_data_o  <= '0;
      prot_drop_o <= 1'b0;
    end else begin
      arr_we_o   <= act_d && rd_vld && !prot_q;
      arr_addr_o <= {base_q, si_d};
      arr_data_o <= rd_data;
      if (act_d && rd_vld && prot_q) prot_drop_o <= 1'b1;
    end
  end

  a_r6_busy_after_go: assert property (@(posedge clk) disable iff (rst)
    commit_go |=> busy_o);
  a_r4_write_in_busy: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> busy_o);
  a_r2_page_fixed: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> (arr_addr_o[ADDR_W-1:PTR_W] == base_q));
  a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(ptr_q));
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    prot_drop_o |=> prot_drop_o);

endmodule

// File: tb/test_wrpage_collect.sv
`timescale 1ns/1ps
module test_wrpage_collect;
  localparam int AW = 12, DW = 8, PG = 32, PC = 48;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, byte_i = 0, stop_i = 0, wp_i = 0;
  logic [AW-1:0] start_addr_i = '0;
  logic [DW-1:0] byte_data_i = '0;
  logic arr_we_o, busy_o, prot_drop_o;
  logic [AW-1:0] arr_addr_o;
  logic [DW-1:0] arr_data_o;

  int n_chk = 0, n_fail = 0;
  logic [AW+DW-1:0] exp_q [$];
  bit exp_flag = 0;

  always #2 clk = ~clk;

  wrpage_collect #(.ADDR_W(AW), .DATA_W(DW), .PAGE(PG), .PROG_CYC(PC)) i_wrpage_collect (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_i(byte_i), .byte_data_i(byte_data_i), .stop_i(stop_i), .wp_i(wp_i),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o),
    .busy_o(busy_o), .prot_drop_o(prot_drop_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every array write
  always @(negedge clk) begin
    if (!rst && arr_we_o) begin
      if (exp_q.size() == 0) chk(0, "R4 unexpected write", int'(arr_addr_o), 0);
      else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        chk({arr_addr_o, arr_data_o} == e, "R2/R3/R4 write addr,data",
            int'({arr_addr_o, arr_data_o}), int'(e));
      end
    end
  end

  // Driver: runs one transaction, models slots, pushes expected writes.
  // inject=1 sends open/byte/end pulses while busy (R7).
  task automatic txn(input int addr, input int n, input bit wp, input int seed, input bit inject);
    logic [DW-1:0] slot [PG];
    bit            vld  [PG];
    bit            prot;
    int            cnt;
    for (int s = 0; s < PG; s++) begin vld[s] = 0; slot[s] = '0; end
    @(negedge clk); start_i = 1; start_addr_i = AW'(addr); wp_i = wp;
    @(negedge clk); start_i = 0;
    for (int i = 0; i < n; i++) begin
      byte_i = 1; byte_data_i = DW'(i * 7 + seed);
      slot[(addr + i) % PG] = byte_data_i; vld[(addr + i) % PG] = 1;
      @(negedge clk);
    end
    byte_i = 0;
    prot = wp && (addr >= 12'hC00);
    if (!prot)
      for (int s = 0; s < PG; s++)
        if (vld[s]) exp_q.push_back({AW'((addr & ~(PG - 1)) | s), slot[s]});
    if (prot && n > 0) exp_flag = 1;
    stop_i = 1;
    @(negedge clk); stop_i = 0;
    cnt = 0;
    while (busy_o) begin
      cnt++;
      if (inject) begin
        start_i = (cnt == 5); start_addr_i = 12'h300;
        byte_i = (cnt == 6); byte_data_i = 8'hEE;
        stop_i = (cnt == 7);
      end
      @(negedge clk);
      start_i = 0; byte_i = 0; stop_i = 0;
    end
    if (n > 0) chk(cnt == PC, "R6 busy length", cnt, PC);
    else       chk(cnt == 0, "R5 no busy on empty", cnt, 0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    chk(prot_drop_o == exp_flag, "R8/R10 lock flag", prot_drop_o, exp_flag);
  endtask

  initial begin
    #(200000 * 4);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy_o == 0, "R1 busy reset", busy_o, 0);
    chk(arr_we_o == 0, "R1 we reset", arr_we_o, 0);
    chk(prot_drop_o == 0, "R1 flag reset", prot_drop_o, 0);

    txn(12'h123, 5, 0, 1, 0);      // R2 plain run
    txn(12'h03E, 4, 0, 2, 0);      // R2 wrap inside page
    txn(12'h200, 35, 0, 3, 0);     // R3 overwrite oldest
    txn(12'h400, 0, 0, 4, 0);      // R5 empty transaction
    txn(12'hC10, 3, 1, 5, 0);      // R8 locked quarter
    txn(12'hFF0, 4, 0, 6, 0);      // R9 quarter unlocked, R10 flag stays
    txn(12'hBF0, 6, 1, 7, 0);      // R9 lock set, below C00h
    txn(12'h050, 2, 0, 8, 1);      // R7 pulses during busy ignored

    // R7: a byte and end with no fresh open must do nothing
    @(negedge clk); byte_i = 1; byte_data_i = 8'h5A;
    @(negedge clk); byte_i = 0; stop_i = 1;
    @(negedge clk); stop_i = 0;
    cnt = 0;
    repeat (60) begin if (busy_o) cnt++; @(negedge clk); end
    chk(cnt == 0, "R7 no commit after ignored open", cnt, 0);
    chk(exp_q.size() == 0, "R7 no pending writes", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule